// File: doc/BRIEF.md
# Multi-mode LCD pixel bus formatter

This block converts pixel streams into beats on a 24-line parallel LCD data bus, with a strobe that marks each beat. There are five panel layouts. In the thin-film (one pixel per beat) layout, each pixel's red, green and blue components go to fixed 8-bit lanes. In the four passive-matrix (STN) layouts, the pixel bits are packed into 4-bit or 8-bit beats. Two of the STN layouts drive one panel. The other two are dual-scan layouts that drive an upper and a lower panel half from two separate streams. In the STN layouts, a colour-select input chooses between one bit per pixel and three bits per pixel.

Both pixel streams use valid/ready handshakes. The bus, the strobe and a line-end flag leave the block from registers. The layout code and the colour select are sampled only when a frame-start pulse arrives, so the bus format can never change in the middle of a frame. Sync and porch timing, frame fetching and palette lookup are handled elsewhere.

Top module: `lcdf_pixel_formatter`

## Requirements
- R1: After reset, `dot_en`, `line_end` and `lcd_data` are zero. The active layout is thin-film, so `up_ready` is 1 and `lo_ready` is 0.
- R2: In the thin-film layout (code 0), an accepted pixel `up_pix = {red, green, blue}` (each COMP_W bits, red in the top bits) appears on the next cycle with `dot_en` high. Red is on `lcd_data[7:0]`, green on `[15:8]` and blue on `[23:16]`. Each component is left-justified in its lane and the low lane bits are zero. `line_end` copies `up_last`.
- R3: In the 4-bit single-scan layout (code 1), beats carry 4 stream bits on `lcd_data[3:0]` and bits `[23:4]` are zero. The earliest stream bit goes on the highest line of the group. In mono, the pixel bit is `up_pix[0]`.
- R4: In colour STN, each pixel contributes `up_pix[2]` (red), then `up_pix[1]` (green), then `up_pix[0]` (blue). The bits flow as one continuous run, so a triplet may be split across two beats. In the 8-bit single-scan layout (code 2), beats are 8 bits on `lcd_data[7:0]` and the bits above are zero.
- R5: When the pixel flagged with `last` has been packed, the final beat of the line is padded with zeros in its low bits and carries `line_end`. The packing state then restarts empty for the next line.
- R6: In the 8-bit dual-scan layout (code 3), the upper stream drives `lcd_data[3:0]` and the lower stream (`lo_pix`) drives `[7:4]`. Bits `[23:8]` are zero.
- R7: In the 16-bit dual-scan layout (code 4), the upper stream drives `lcd_data[7:0]` and the lower stream drives `[15:8]`. Bits `[23:16]` are zero.
- R8: In the dual-scan layouts, a beat is issued only when both halves hold a full beat or the rest of a line. Until then `dot_en` stays low, and a half that is already full deasserts its ready.
- R9: A new layout code or colour select takes effect only on a `frame_start` cycle. That cycle also discards any partly packed bits. During it, neither input is accepted and no beat is issued.
- R10: A `frame_start` that carries a code from 5 to 7 leaves the active layout and colour select unchanged.
- R11: While `dot_en` is low, `lcd_data` is zero and `line_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame boundary pulse; latches layout and colour select |
| mode_sel | input | 3 | Layout code: 0 thin-film, 1 STN 4-bit, 2 STN 8-bit, 3 dual 8-bit, 4 dual 16-bit |
| color_sel | input | 1 | STN colour select: 1 gives three bits per pixel, 0 gives one |
| up_valid | input | 1 | Upper / single stream valid |
| up_ready | output | 1 | Upper / single stream ready |
| up_pix | input | 3*COMP_W | Pixel: full RGB in thin-film, low 3 or 1 bits in STN |
| up_last | input | 1 | Last pixel of a line on the upper stream |
| lo_valid | input | 1 | Lower-half stream valid (dual scan only) |
| lo_ready | output | 1 | Lower-half stream ready |
| lo_pix | input | 3 | Lower-half pixel bits (RGB in bits 2..0, mono in bit 0) |
| lo_last | input | 1 | Last pixel of a line on the lower stream |
| dot_en | output | 1 | Beat strobe |
| lcd_data | output | 3*LANE_W | Panel data bus |
| line_end | output | 1 | Marks the final beat of a line |

## Verification
The embedded assertions check on every cycle that the lines unused by the active layout stay zero, that the padding bits of the thin-film lanes stay zero, and that the idle bus is clear. They also check that a line-end flag never appears without a strobe, that the active layout moves only on a frame-start pulse that carries a legal code, and that each packer's bit count stays within its bound and empties when cleared. Which stream bit lands on which line can be shown only by the bench's scenarios. The same holds for how colour triplets split across beats, for the zero padding of a short final beat, for dual-scan stalling while one half waits, and for partial bits being discarded at a frame boundary.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

  typedef enum logic [2:0] {
    MODE_TFT    = 3'd0,
    MODE_STN4   = 3'd1,
    MODE_STN8   = 3'd2,
    MODE_DUAL8  = 3'd3,
    MODE_DUAL16 = 3'd4
  } lcd_mode_e;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic mode_is_dual(input lcd_mode_e m);
    return (m == MODE_DUAL8) || (m == MODE_DUAL16);
  endfunction

  function automatic logic mode_is_wide(input lcd_mode_e m);
    return (m == MODE_STN8) || (m == MODE_DUAL16);
  endfunction

endpackage

// File: rtl/lcdf_mode_ctrl.sv
module lcdf_mode_ctrl
  import lcdf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [2:0] mode_sel,
  input  logic       color_sel,
  output lcd_mode_e  act_mode,
  output logic       act_color
);

  lcd_mode_e mode_q, mode_d;
  logic      color_q, color_d;
  logic      load;

  assign load = frame_start && mode_code_ok(mode_sel);

  always_comb begin
    mode_d  = mode_q;
    color_d = color_q;
    if (load) begin
      mode_d  = lcd_mode_e'(mode_sel);
      color_d = color_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_TFT;
      color_q <= 1'b0;
    end else if (load) begin
      mode_q  <= mode_d;
      color_q <= color_d;
    end
  end

  assign act_mode  = mode_q;
  assign act_color = color_q;

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(mode_q) && $stable(color_q)));

  assert_bad_code_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (mode_sel > 3'd4)) |=> ($stable(mode_q) && $stable(color_q)));

endmodule

// File: rtl/lcdf_bit_packer.sv
module lcdf_bit_packer #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wide,
  input  logic              color,
  input  logic              in_valid,
  input  logic [2:0]        in_bits,
  input  logic              in_last,
  output logic              in_ready,
  output logic              beat_avail,
  output logic              beat_final,
  output logic [LANE_W-1:0] beat_data,
  input  logic              pop
);

  localparam int HALF  = LANE_W / 2;
  localparam int ACC_W = 2 * LANE_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_d, ins;
  logic [CNT_W-1:0] cnt_q, cnt_d, bw, nbits, shamt;
  logic             pend_q, pend_d;
  logic             accept, take, en;

  assign bw    = wide  ? CNT_W'(LANE_W) : CNT_W'(HALF);
  assign nbits = color ? CNT_W'(3) : CNT_W'(1);
  assign shamt = CNT_W'(ACC_W) - cnt_q - nbits;
  assign ins   = color ? ACC_W'(in_bits) : ACC_W'(in_bits[0]);

  assign in_ready   = !clr && !pend_q && (cnt_q < bw);
  assign beat_avail = !clr && ((cnt_q >= bw) || (pend_q && (cnt_q != '0)));
  assign beat_final = pend_q && (cnt_q <= bw);
  assign beat_data  = wide ? acc_q[ACC_W-1 -: LANE_W]
                           : {{(LANE_W-HALF){1'b0}}, acc_q[ACC_W-1 -: HALF]};

  assign accept = in_valid && in_ready;
  assign take   = pop && beat_avail;
  assign en     = clr || accept || take;

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (clr) begin
      acc_d  = '0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (accept) begin
      acc_d  = acc_q | (ins << shamt);
      cnt_d  = cnt_q + nbits;
      pend_d = in_last;
    end else if (take) begin
      if (beat_final) begin
        acc_d  = '0;
        cnt_d  = '0;
        pend_d = 1'b0;
      end else begin
        acc_d = wide ? (acc_q << LANE_W) : (acc_q << HALF);
        cnt_d = cnt_q - bw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (en) begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (bw + CNT_W'(2)));

  assert_pend_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q != '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((cnt_q == '0) && !pend_q));

endmodule

// File: rtl/lcdf_lane_mux.sv
module lcdf_lane_mux
  import lcdf_pkg::*;
#(
  parameter int COMP_W = 6,
  parameter int LANE_W = 8
) (
  input  lcd_mode_e             mode,
  input  logic [3*COMP_W-1:0]   tft_pix,
  input  logic [LANE_W-1:0]     up_beat,
  input  logic [LANE_W-1:0]     lo_beat,
  output logic [3*LANE_W-1:0]   bus
);

  localparam int HALF  = LANE_W / 2;
  localparam int BUS_W = 3 * LANE_W;
  localparam int PAD_W = LANE_W - COMP_W;

  logic [BUS_W-1:0] tft_bus;
  logic [BUS_W-1:0] stn_bus;

  // lane 0 red, lane 1 green, lane 2 blue; red sits in the top of tft_pix
  for (genvar l = 0; l < 3; l++) begin : g_lane
    assign tft_bus[l*LANE_W +: LANE_W] =
      LANE_W'(tft_pix[(2-l)*COMP_W +: COMP_W]) << PAD_W;
  end

  always_comb begin
    stn_bus = '0;
    case (mode)
      MODE_STN4:   stn_bus[HALF-1:0] = up_beat[HALF-1:0];
      MODE_STN8:   stn_bus[LANE_W-1:0] = up_beat;
      MODE_DUAL8: begin
        stn_bus[HALF-1:0]      = up_beat[HALF-1:0];
        stn_bus[LANE_W-1:HALF] = lo_beat[HALF-1:0];
      end
      MODE_DUAL16: begin
        stn_bus[LANE_W-1:0]        = up_beat;
        stn_bus[2*LANE_W-1:LANE_W] = lo_beat;
      end
      default:     stn_bus = '0;
    endcase
  end

  assign bus = (mode == MODE_TFT) ? tft_bus : stn_bus;

endmodule

// File: rtl/lcdf_pixel_formatter.sv
module lcdf_pixel_formatter
  import lcdf_pkg::*;
#(
  parameter int COMP_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [2:0]            mode_sel,
  input  logic                  color_sel,
  input  logic                  up_valid,
  output logic                  up_ready,
  input  logic [3*COMP_W-1:0]   up_pix,
  input  logic                  up_last,
  input  logic                  lo_valid,
  output logic                  lo_ready,
  input  logic [2:0]            lo_pix,
  input  logic                  lo_last,
  output logic                  dot_en,
  output logic [3*LANE_W-1:0]   lcd_data,
  output logic                  line_end
);

  localparam int HALF  = LANE_W / 2;
  localparam int BUS_W = 3 * LANE_W;
  localparam int PAD_W = LANE_W - COMP_W;

  function automatic logic [BUS_W-1:0] tft_pad_mask();
    logic [BUS_W-1:0] m;
    m = '0;
    for (int l = 0; l < 3; l++)
      for (int b = 0; b < PAD_W; b++)
        m[l*LANE_W + b] = 1'b1;
    return m;
  endfunction

  localparam logic [BUS_W-1:0] TFT_PAD = tft_pad_mask();

  lcd_mode_e act_mode;
  logic      act_color;
  logic      is_tft, is_dual, is_wide;

  lcdf_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_sel    (mode_sel),
    .color_sel   (color_sel),
    .act_mode    (act_mode),
    .act_color   (act_color)
  );

  assign is_tft  = (act_mode == MODE_TFT);
  assign is_dual = mode_is_dual(act_mode);
  assign is_wide = mode_is_wide(act_mode);

  // index 0 = upper / single panel, index 1 = lower panel
  logic [1:0]        pk_valid, pk_last, pk_ready, pk_avail, pk_final;
  logic [2:0]        pk_bits [2];
  logic [LANE_W-1:0] pk_beat [2];
  logic              pop;

  assign pk_valid[0] = up_valid && !is_tft;
  assign pk_valid[1] = lo_valid && is_dual;
  assign pk_last[0]  = up_last;
  assign pk_last[1]  = lo_last;
  assign pk_bits[0]  = up_pix[2:0];
  assign pk_bits[1]  = lo_pix;

  for (genvar g = 0; g < 2; g++) begin : g_half
    lcdf_bit_packer #(.LANE_W(LANE_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (frame_start),
      .wide       (is_wide),
      .color      (act_color),
      .in_valid   (pk_valid[g]),
      .in_bits    (pk_bits[g]),
      .in_last    (pk_last[g]),
      .in_ready   (pk_ready[g]),
      .beat_avail (pk_avail[g]),
      .beat_final (pk_final[g]),
      .beat_data  (pk_beat[g]),
      .pop        (pop)
    );
  end

  assign pop = !frame_start && !is_tft && pk_avail[0] && (!is_dual || pk_avail[1]);

  assign up_ready = !frame_start && (is_tft || pk_ready[0]);
  assign lo_ready = is_dual && pk_ready[1];

  logic [BUS_W-1:0] mux_bus;

  lcdf_lane_mux #(.COMP_W(COMP_W), .LANE_W(LANE_W)) u_mux (
    .mode    (act_mode),
    .tft_pix (up_pix),
    .up_beat (pk_beat[0]),
    .lo_beat (pk_beat[1]),
    .bus     (mux_bus)
  );

  logic             tft_take;
  logic             strobe_d, line_d;
  logic [BUS_W-1:0] data_d;
  logic             strobe_q, line_q;
  logic [BUS_W-1:0] data_q;

  assign tft_take = is_tft && up_valid && !frame_start;

  always_comb begin
    strobe_d = pop || tft_take;
    line_d   = tft_take ? up_last : (pop && pk_final[0]);
    data_d   = strobe_d ? mux_bus : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      line_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_d;
      line_q   <= line_d;
      data_q   <= data_d;
    end
  end

  assign dot_en   = strobe_q;
  assign line_end = line_q;
  assign lcd_data = data_q;

  assert_idle_bus_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |-> ((lcd_data == '0) && !line_end));

  assert_tft_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && is_tft) |-> ((lcd_data & TFT_PAD) == '0));

  assert_stn4_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_STN4) |-> ((lcd_data >> HALF) == '0));

  assert_stn8_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_STN8) |-> ((lcd_data >> LANE_W) == '0));

  assert_dual8_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_DUAL8) |-> ((lcd_data >> LANE_W) == '0));

  assert_dual16_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_DUAL16) |-> ((lcd_data >> (2*LANE_W)) == '0));

  assert_no_beat_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !dot_en);

  assert_lower_idle_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dual |-> !lo_ready);

endmodule

// File: tb/sim_lcdf_pixel_formatter.sv
module sim_lcdf_pixel_formatter;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 18;
  localparam int BUS_W      = 24;
  localparam int WD_CYCLES  = 50000;

  logic             clk, rst_n, frame_start, color_sel;
  logic [2:0]       mode_sel;
  logic             up_valid, up_ready, up_last;
  logic [PIX_W-1:0] up_pix;
  logic             lo_valid, lo_ready, lo_last;
  logic [2:0]       lo_pix;
  logic             dot_en, line_end;
  logic [BUS_W-1:0] lcd_data;

  lcdf_pixel_formatter u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
    .color_sel(color_sel), .up_valid(up_valid), .up_ready(up_ready),
    .up_pix(up_pix), .up_last(up_last), .lo_valid(lo_valid), .lo_ready(lo_ready),
    .lo_pix(lo_pix), .lo_last(lo_last), .dot_en(dot_en), .lcd_data(lcd_data),
    .line_end(line_end)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int nb = 0;
  int viol = 0;
  logic [BUS_W-1:0] rec_data [0:63];
  logic             rec_le   [0:63];

  always @(negedge clk) begin
    if (rst_n) begin
      if ((!dot_en && lcd_data != '0) || (line_end && !dot_en)) viol++;
      if (dot_en && nb < 64) begin
        rec_data[nb] = lcd_data;
        rec_le[nb]   = line_end;
        nb++;
      end
    end
  end

  // {pix[17:0], last, expected bus[23:0], expected line_end}
  localparam logic [43:0] VEC [0:3] = '{
    {18'h3F000, 1'b0, 24'h0000FC, 1'b0},
    {18'h00040, 1'b0, 24'h000400, 1'b0},
    {18'h00021, 1'b0, 24'h840000, 1'b0},
    {18'h15A8F, 1'b1, 24'h3CA854, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push_up(input logic [PIX_W-1:0] p, input logic l);
    up_pix = p; up_last = l; up_valid = 1'b1;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0; up_last = 1'b0;
  endtask

  task automatic push_lo(input logic [2:0] p, input logic l);
    lo_pix = p; lo_last = l; lo_valid = 1'b1;
    while (!lo_ready) @(negedge clk);
    @(negedge clk);
    lo_valid = 1'b0; lo_last = 1'b0;
  endtask

  task automatic start_frame(input logic [2:0] m, input logic c);
    mode_sel = m; color_sel = c; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; frame_start = 1'b0; mode_sel = 3'd0; color_sel = 1'b0;
    up_valid = 1'b0; up_pix = '0; up_last = 1'b0;
    lo_valid = 1'b0; lo_pix = '0; lo_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dot_en in reset", 32'(dot_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dot_en", 32'(dot_en), 32'd0);
    chk("R1 line_end", 32'(line_end), 32'd0);
    chk("R1 lcd_data", 32'(lcd_data), 32'd0);
    chk("R1 up_ready thin-film", 32'(up_ready), 32'd1);
    chk("R1 lo_ready", 32'(lo_ready), 32'd0);

    // R2: table of thin-film pixels, active layout from reset
    base = nb;
    for (int i = 0; i < 4; i++) push_up(VEC[i][43:26], VEC[i][25]);
    settle();
    chk("R2 beat count", 32'(nb - base), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 tft lanes", 32'(rec_data[base+i]), 32'(VEC[i][24:1]));
      chk("R2 tft line_end", 32'(rec_le[base+i]), 32'(VEC[i][0]));
    end

    // R3 / R5: 4-bit mono, 6 pixels then 4 pixels
    start_frame(3'd1, 1'b0);
    base = nb;
    push_up(18'd1, 0); push_up(18'd0, 0); push_up(18'd1, 0);
    push_up(18'd1, 0); push_up(18'd0, 0); push_up(18'd1, 1);
    settle();
    chk("R3 beat count", 32'(nb - base), 32'd2);
    chk("R3 first beat msb-first", 32'(rec_data[base]), 32'h0000000B);
    chk("R3 first no line_end", 32'(rec_le[base]), 32'd0);
    chk("R5 padded last beat", 32'(rec_data[base+1]), 32'h00000004);
    chk("R5 line_end on last", 32'(rec_le[base+1]), 32'd1);
    base = nb;
    push_up(18'd1, 0); push_up(18'd1, 0); push_up(18'd0, 0); push_up(18'd1, 1);
    settle();
    chk("R5 fresh line count", 32'(nb - base), 32'd1);
    chk("R5 fresh line data", 32'(rec_data[base]), 32'h0000000D);
    chk("R5 fresh line flag", 32'(rec_le[base]), 32'd1);

    // R9: partial bits dropped; code change without frame_start ignored
    base = nb;
    push_up(18'd1, 0); push_up(18'd1, 0);
    mode_sel = 3'd2;
    settle();
    chk("R9 no beat from partial", 32'(nb - base), 32'd0);
    start_frame(3'd1, 1'b0);
    mode_sel = 3'd2;
    push_up(18'd0, 0); push_up(18'd0, 0); push_up(18'd0, 0); push_up(18'd1, 1);
    settle();
    chk("R9 beat count", 32'(nb - base), 32'd1);
    chk("R9 partial cleared and layout held", 32'(rec_data[base]), 32'h00000001);

    // R10: reserved code keeps 4-bit mono
    start_frame(3'd7, 1'b1);
    base = nb;
    push_up(18'd1, 0); push_up(18'd0, 0); push_up(18'd1, 0); push_up(18'd0, 1);
    settle();
    chk("R10 beat count", 32'(nb - base), 32'd1);
    chk("R10 layout unchanged", 32'(rec_data[base]), 32'h0000000A);
    chk("R10 line_end", 32'(rec_le[base]), 32'd1);

    // R4: 8-bit colour, triplet split
    start_frame(3'd2, 1'b1);
    base = nb;
    push_up(18'b101, 0); push_up(18'b011, 0); push_up(18'b111, 1);
    settle();
    chk("R4 beat count", 32'(nb - base), 32'd2);
    chk("R4 rgb run", 32'(rec_data[base]), 32'h000000AF);
    chk("R4 split triplet padded", 32'(rec_data[base+1]), 32'h00000080);
    chk("R4 line_end last", 32'(rec_le[base+1]), 32'd1);

    // R6 / R8: dual 8-bit mono, upper first then lower
    start_frame(3'd3, 1'b0);
    base = nb;
    push_up(18'd1, 0); push_up(18'd0, 0); push_up(18'd0, 0); push_up(18'd1, 1);
    settle();
    chk("R8 no beat with lower empty", 32'(nb - base), 32'd0);
    chk("R8 upper stalled", 32'(up_ready), 32'd0);
    push_lo(3'd0, 0); push_lo(3'd1, 0); push_lo(3'd1, 0); push_lo(3'd1, 1);
    settle();
    chk("R8 beat after both", 32'(nb - base), 32'd1);
    chk("R6 dual lanes", 32'(rec_data[base]), 32'h00000079);
    chk("R6 line_end", 32'(rec_le[base]), 32'd1);

    // R7: dual 16-bit colour, streams in parallel
    start_frame(3'd4, 1'b1);
    base = nb;
    fork
      begin push_up(18'b110, 0); push_up(18'b001, 0); push_up(18'b011, 1); end
      begin push_lo(3'b010, 0); push_lo(3'b100, 0); push_lo(3'b111, 1); end
    join
    settle();
    chk("R7 beat count", 32'(nb - base), 32'd2);
    chk("R7 first beat lanes", 32'(rec_data[base]), 32'h000053C5);
    chk("R7 first no line_end", 32'(rec_le[base]), 32'd0);
    chk("R7 padded last beat", 32'(rec_data[base+1]), 32'h00008080);
    chk("R7 line_end", 32'(rec_le[base+1]), 32'd1);

    chk("R11 idle bus clear", 32'(viol), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule